// File: doc/BRIEF.md
# Locked Configuration Register Port

This block gives a host access to the configuration registers of a legacy I/O controller through two byte-wide ports. One port is the index port, normally decoded at I/O address 0x2E. The other is the data port, at 0x2F. The bus cycle decoding sits outside the block. Each host access reaches the block as one request on a valid/ready stream. The request carries a port select, a read/write flag and a write byte. Each read returns exactly one byte on a response stream.

After reset the configuration space is locked. To unlock it, the host writes a fixed four-byte key (0x87, 0x01, 0x55, 0x55) to the index port. Once the space is unlocked, index-port writes set an index latch, and data-port accesses read or write the register that the latch selects. Some registers are global to the whole controller: the exit command, the logical device number, the identity and the revision. Indices at or above the bank base (0x30) belong to the device selected by the logical device number. Accesses to those indices are passed out through a registered bank interface. Writing 0x02 to index 0x02 locks the space again.

Back-pressure works as follows. Only one request is in flight at a time. `req_ready` is low while a bank read is waiting for its data and while a response is held. A response stays valid, and its data stays stable, until the host raises `rsp_ready`. Write requests produce no response.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, `req_ready` is 1, `rsp_valid` is 0, both bank strobes are 0, the index latch is 0x00 and the logical device number is 0.
- R2: While locked, the space unlocks only after index-port writes of exactly 0x87, 0x01, 0x55, 0x55 in order. A write that breaks the sequence returns the matcher to its first step. If that breaking write is 0x87, the matcher instead resumes at its second step.
- R3: While locked, reads of either port return 0xFF. Data-port writes change no register and raise no bank strobe.
- R4: While unlocked, an index-port write sets the index latch and an index-port read returns it. The latch keeps its value, so repeated data-port accesses reach the same register.
- R5: Index 0x20 reads the identity high byte and 0x21 the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 reading 0. Writes to these three indices are ignored.
- R6: Index 0x07 holds the logical device number, which reads back what was last written.
- R7: An unlocked data-port write to an index at or above 0x30 raises `bank_wr_stb` for exactly the one cycle after acceptance. In that cycle `bank_addr` carries the index, `bank_wdata` the byte and `bank_ldn` the current logical device number.
- R8: An unlocked data-port read of an index at or above 0x30 raises `bank_rd_stb` for the one cycle after acceptance, with address and device number as in R7. The `bank_rdata` value in that cycle becomes the response on the next cycle.
- R9: A data-port write of 0x02 to index 0x02 relocks the space, clears the index latch and resets the key matcher. Any other value written there is ignored.
- R10: While a response is held or a bank read is pending, `req_ready` is 0. A held response keeps `rsp_valid` and `rsp_data` stable until `rsp_ready` is 1.
- R11: While unlocked, global indices below 0x30 other than 0x02, 0x07, 0x20, 0x21 and 0x22 read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_is_data | input | 1 | 1 selects the data port, 0 the index port |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 8 | Byte written by the host |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| bank_wr_stb | output | 1 | One-cycle banked register write strobe |
| bank_rd_stb | output | 1 | One-cycle banked register read strobe |
| bank_addr | output | 8 | Registered banked register index |
| bank_wdata | output | 8 | Registered banked write byte |
| bank_ldn | output | LDN_W | Logical device number qualifying the bank access |
| bank_rdata | input | 8 | Banked read byte, valid while `bank_rd_stb` is high |

## Verification
The bench builds the block with identity 0xC0DE and revision 9. These values keep the identity bytes and the revision nibble apart from the reset values and from 0xFF. The key and the bank base keep their default values (0x87015555 and 0x30), so the broken-key and restart cases use the real byte sequence, including the repeated 0x55. The bench's bank model keys its storage on the low bits of the device number and the index. A write under one device number and a read under another therefore return visibly different bytes.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] EXIT_CMD    = 8'h02;
  localparam logic [7:0] LOCKED_BYTE = 8'hFF;
endpackage

// File: rtl/sio_key_matcher.sv
module sio_key_matcher #(
  parameter int KEY_LEN = 4,
  parameter logic [8*KEY_LEN-1:0] KEY = 32'h8701_5555
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic       hit
);
  localparam int STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);
  localparam logic [7:0] FIRST_BYTE = KEY[8*KEY_LEN-1 -: 8];

  logic [STEP_W-1:0] step_q, step_d;
  logic [7:0]        expect_byte;
  logic              match;

  // byte expected at the current step, first key byte in the top bits
  always_comb expect_byte = KEY[(KEY_LEN - 1 - int'(step_q)) * 8 +: 8];
  assign match = (wr_byte == expect_byte);
  assign hit   = wr_en && !clear && match && (step_q == LAST_STEP);

  always_comb begin
    step_d = step_q;
    if (clear) begin
      step_d = '0;
    end else if (wr_en) begin
      if (match) step_d = (step_q == LAST_STEP) ? '0 : step_q + 1'b1;
      else if (wr_byte == FIRST_BYTE) step_d = STEP_W'(1);
      else step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs import sio_cfg_pkg::*; #(
  parameter logic [15:0] CHIP_ID  = 16'h5A17,
  parameter logic [3:0]  CHIP_REV = 4'h1,
  parameter int          LDN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  output logic [LDN_W-1:0] ldn,
  output logic [7:0]       rdata
);
  logic [LDN_W-1:0] ldn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ldn_q <= '0;
    else if (wr_en && idx == IDX_LDN)    ldn_q <= wdata[LDN_W-1:0];
  end

  always_comb begin
    unique case (idx)
      IDX_LDN:   rdata = 8'(ldn_q);
      IDX_ID_HI: rdata = CHIP_ID[15:8];
      IDX_ID_LO: rdata = CHIP_ID[7:0];
      IDX_REV:   rdata = {4'h0, CHIP_REV};
      default:   rdata = 8'h00;
    endcase
  end

  assign ldn = ldn_q;
endmodule

// File: rtl/sio_bank_port.sv
module sio_bank_port #(
  parameter int LDN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_wr,
  input  logic             issue_rd,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  input  logic [LDN_W-1:0] ldn,
  output logic             wr_stb,
  output logic             rd_stb,
  output logic [7:0]       addr,
  output logic [7:0]       wdata_q,
  output logic [LDN_W-1:0] ldn_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      addr    <= '0;
      wdata_q <= '0;
      ldn_q   <= '0;
    end else begin
      wr_stb <= issue_wr;
      rd_stb <= issue_rd;
      if (issue_wr || issue_rd) begin
        addr  <= idx;
        ldn_q <= ldn;
      end
      if (issue_wr) wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port import sio_cfg_pkg::*; #(
  parameter int                   KEY_LEN    = 4,
  parameter logic [8*KEY_LEN-1:0] UNLOCK_KEY = 32'h8701_5555,
  parameter logic [15:0]          CHIP_ID    = 16'h5A17,
  parameter logic [3:0]           CHIP_REV   = 4'h1,
  parameter logic [7:0]           BANK_BASE  = 8'h30,
  parameter int                   LDN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_data,
  input  logic             req_write,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             bank_wr_stb,
  output logic             bank_rd_stb,
  output logic [7:0]       bank_addr,
  output logic [7:0]       bank_wdata,
  output logic [LDN_W-1:0] bank_ldn,
  input  logic [7:0]       bank_rdata
);
  logic             unlocked_q;
  logic [7:0]       idx_q;
  logic             rsp_valid_q;
  logic [7:0]       rsp_data_q;
  logic             rd_wait_q;

  logic             accept, idx_in_bank;
  logic             key_wr, idx_wr, data_wr, data_rd;
  logic             exit_cmd, glob_wr, bank_wr, bank_rd, imm_rd;
  logic             key_hit;
  logic [7:0]       glob_rdata, imm_data;
  logic [LDN_W-1:0] ldn;

  assign req_ready   = !rsp_valid_q && !rd_wait_q;
  assign accept      = req_valid && req_ready;
  assign idx_in_bank = (idx_q >= BANK_BASE);

  assign key_wr   = accept && !req_is_data && req_write && !unlocked_q;
  assign idx_wr   = accept && !req_is_data && req_write &&  unlocked_q;
  assign data_wr  = accept &&  req_is_data && req_write &&  unlocked_q;
  assign data_rd  = accept &&  req_is_data && !req_write;
  assign exit_cmd = data_wr && (idx_q == IDX_EXIT) && (req_wdata == EXIT_CMD);
  assign glob_wr  = data_wr && !idx_in_bank;
  assign bank_wr  = data_wr &&  idx_in_bank;
  assign bank_rd  = data_rd && unlocked_q && idx_in_bank;
  assign imm_rd   = accept && !req_write && !bank_rd;

  sio_key_matcher #(.KEY_LEN(KEY_LEN), .KEY(UNLOCK_KEY)) key_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (exit_cmd),
    .wr_en   (key_wr),
    .wr_byte (req_wdata),
    .hit     (key_hit)
  );

  sio_global_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .LDN_W(LDN_W)) glob_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (glob_wr),
    .idx   (idx_q),
    .wdata (req_wdata),
    .ldn   (ldn),
    .rdata (glob_rdata)
  );

  sio_bank_port #(.LDN_W(LDN_W)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_wr (bank_wr),
    .issue_rd (bank_rd),
    .idx      (idx_q),
    .wdata    (req_wdata),
    .ldn      (ldn),
    .wr_stb   (bank_wr_stb),
    .rd_stb   (bank_rd_stb),
    .addr     (bank_addr),
    .wdata_q  (bank_wdata),
    .ldn_q    (bank_ldn)
  );

  always_comb begin
    if (!unlocked_q)       imm_data = LOCKED_BYTE;
    else if (!req_is_data) imm_data = idx_q;
    else                   imm_data = glob_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q  <= 1'b0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rd_wait_q   <= 1'b0;
    end else begin
      if (key_hit)       unlocked_q <= 1'b1;
      else if (exit_cmd) unlocked_q <= 1'b0;

      if (exit_cmd)    idx_q <= '0;
      else if (idx_wr) idx_q <= req_wdata;

      if (rd_wait_q) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= bank_rdata;
        rd_wait_q   <= 1'b0;
      end else if (imm_rd) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= imm_data;
      end else if (rsp_valid_q && rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end

      if (bank_rd) rd_wait_q <= 1'b1;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [7:0] BANK_BASE = 8'h30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       bank_wr_stb,
  input logic       bank_rd_stb,
  input logic [7:0] bank_addr,
  input logic       unlocked
);
  // R3: a locked space never drives the bank interface
  a_r3_no_bank_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!bank_wr_stb && !bank_rd_stb));

  // R7: bank strobes only carry indices inside the banked range
  a_r7_bank_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr_stb || bank_rd_stb) |-> (bank_addr >= BANK_BASE));

  // R7 / R8: one access kind per strobe cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_wr_stb && bank_rd_stb));

  // R8: a bank read strobe yields a response on the next cycle
  a_r8_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd_stb |=> rsp_valid);

  // R10: no new request while a response is held
  a_r10_busy_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10: a stalled response keeps its data
  a_r10_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.BANK_BASE(BANK_BASE)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .bank_wr_stb (bank_wr_stb),
  .bank_rd_stb (bank_rd_stb),
  .bank_addr   (bank_addr),
  .unlocked    (unlocked_q)
);

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_is_data = 1'b0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_ready = 1'b1;
  logic       req_ready, rsp_valid, bank_wr_stb, bank_rd_stb;
  logic [7:0] rsp_data, bank_addr, bank_wdata, bank_rdata;
  logic [7:0] bank_ldn;

  int nvec = 0;
  int nfail = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] last_waddr, last_wdata, last_wldn;
  logic [7:0] bmem [64];
  logic [5:0] bidx;

  always #2 clk = ~clk;

  sio_cfg_port #(.CHIP_ID(16'hC0DE), .CHIP_REV(4'h9)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_data(req_is_data),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bank_wr_stb(bank_wr_stb), .bank_rd_stb(bank_rd_stb), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_ldn(bank_ldn), .bank_rdata(bank_rdata)
  );

  // bank model: storage keyed on device number low bits and index low bits
  assign bidx = {bank_ldn[1:0], bank_addr[3:0]};
  assign bank_rdata = bmem[bidx];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) bmem[i] <= 8'h80 | 8'(i);
    end else begin
      if (bank_wr_stb) begin
        bmem[bidx] <= bank_wdata;
        wr_cnt     <= wr_cnt + 1;
        last_waddr <= bank_addr;
        last_wdata <= bank_wdata;
        last_wldn  <= bank_ldn;
      end
      if (bank_rd_stb) rd_cnt <= rd_cnt + 1;
    end
  end

  function automatic string tag(input logic [3:0] t);
    case (t)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic acc(input logic sel, input logic wr, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_is_data = sel; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    r = 8'h00;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      r = rsp_data;
    end
  endtask

  task automatic iwr(input logic [7:0] d);
    logic [7:0] x;
    acc(1'b0, 1'b1, d, x);
  endtask

  task automatic dwr(input logic [7:0] d);
    logic [7:0] x;
    acc(1'b1, 1'b1, d, x);
  endtask

  // {tag[3:0], is_data, write, wdata[7:0], check, expected[7:0]}
  localparam int NV = 39;
  localparam logic [22:0] VEC [NV] = '{
    {4'd3, 1'b1, 1'b0, 8'h00, 1'b1, 8'hFF},
    {4'd3, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFF},
    {4'd3, 1'b1, 1'b1, 8'h07, 1'b0, 8'h00},
    {4'd2, 1'b0, 1'b1, 8'h87, 1'b0, 8'h00},
    {4'd2, 1'b0, 1'b1, 8'h01, 1'b0, 8'h00},
    {4'd2, 1'b0, 1'b1, 8'h55, 1'b0, 8'h00},
    {4'd2, 1'b0, 1'b1, 8'h55, 1'b0, 8'h00},
    {4'd4, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00},
    {4'd4, 1'b0, 1'b1, 8'h20, 1'b0, 8'h00},
    {4'd5, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC0},
    {4'd4, 1'b1, 1'b0, 8'h00, 1'b1, 8'hC0},
    {4'd4, 1'b0, 1'b0, 8'h00, 1'b1, 8'h20},
    {4'd4, 1'b0, 1'b1, 8'h21, 1'b0, 8'h00},
    {4'd5, 1'b1, 1'b0, 8'h00, 1'b1, 8'hDE},
    {4'd5, 1'b0, 1'b1, 8'h22, 1'b0, 8'h00},
    {4'd5, 1'b1, 1'b0, 8'h00, 1'b1, 8'h09},
    {4'd5, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00},
    {4'd5, 1'b1, 1'b0, 8'h00, 1'b1, 8'h09},
    {4'd6, 1'b0, 1'b1, 8'h07, 1'b0, 8'h00},
    {4'd6, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00},
    {4'd6, 1'b1, 1'b1, 8'h03, 1'b0, 8'h00},
    {4'd6, 1'b1, 1'b0, 8'h00, 1'b1, 8'h03},
    {4'd7, 1'b0, 1'b1, 8'h30, 1'b0, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h5A, 1'b0, 8'h00},
    {4'd8, 1'b1, 1'b0, 8'h00, 1'b1, 8'h5A},
    {4'd6, 1'b0, 1'b1, 8'h07, 1'b0, 8'h00},
    {4'd6, 1'b1, 1'b1, 8'h01, 1'b0, 8'h00},
    {4'd8, 1'b0, 1'b1, 8'h31, 1'b0, 8'h00},
    {4'd8, 1'b1, 1'b0, 8'h00, 1'b1, 8'h91},
    {4'd11, 1'b0, 1'b1, 8'h10, 1'b0, 8'h00},
    {4'd11, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00},
    {4'd11, 1'b1, 1'b1, 8'h44, 1'b0, 8'h00},
    {4'd11, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00},
    {4'd9, 1'b0, 1'b1, 8'h02, 1'b0, 8'h00},
    {4'd9, 1'b1, 1'b1, 8'h01, 1'b0, 8'h00},
    {4'd9, 1'b0, 1'b0, 8'h00, 1'b1, 8'h02},
    {4'd9, 1'b1, 1'b1, 8'h02, 1'b0, 8'h00},
    {4'd9, 1'b1, 1'b0, 8'h00, 1'b1, 8'hFF},
    {4'd9, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFF}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", {7'd0, req_ready}, 8'h01);
    check("R1", {7'd0, rsp_valid}, 8'h00);
    check("R1", {6'd0, bank_wr_stb, bank_rd_stb}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][18], VEC[i][17], VEC[i][16:9], r);
      if (VEC[i][8]) check(tag(VEC[i][22:19]), r, VEC[i][7:0]);
    end

    @(negedge clk);
    // R3 and R7: the locked data write raised no strobe; one bank write seen
    check("R3", 8'(wr_cnt), 8'd1);
    check("R7", last_waddr, 8'h30);
    check("R7", last_wdata, 8'h5A);
    check("R7", last_wldn, 8'h03);
    check("R8", 8'(rd_cnt), 8'd2);

    // R2: a 0x87 inside the key restarts at the second step
    iwr(8'h87); iwr(8'h01); iwr(8'h87); iwr(8'h01); iwr(8'h55); iwr(8'h55);
    acc(1'b0, 1'b0, 8'h00, r);
    check("R2", r, 8'h00);
    iwr(8'h02); dwr(8'h02);

    // R2: a broken key stays locked
    iwr(8'h87); iwr(8'h01); iwr(8'h55); iwr(8'h00); iwr(8'h55);
    acc(1'b1, 1'b0, 8'h00, r);
    check("R2", r, 8'hFF);
    iwr(8'h87); iwr(8'h01); iwr(8'h55); iwr(8'h55);
    acc(1'b0, 1'b0, 8'h00, r);
    check("R2", r, 8'h00);

    // R6: the device number survives a relock
    iwr(8'h07);
    acc(1'b1, 1'b0, 8'h00, r);
    check("R6", r, 8'h01);

    // R10: a stalled response holds and blocks new requests
    iwr(8'h20);
    rsp_ready = 1'b0;
    acc(1'b1, 1'b0, 8'h00, r);
    repeat (3) @(negedge clk);
    check("R10", {7'd0, rsp_valid}, 8'h01);
    check("R10", {7'd0, req_ready}, 8'h00);
    check("R10", rsp_data, 8'hC0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10", {7'd0, rsp_valid}, 8'h00);
    check("R10", {7'd0, req_ready}, 8'h01);

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule